// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer

This block runs the fetch and execute pipeline of a small controller whose instructions are 16 bits wide. Every instruction cycle is split into four phase clocks, Q1 to Q4. In each cycle the block fetches one word from program memory and executes the word it fetched in the previous cycle. It keeps a byte-addressed program counter and drives the program-memory address. Operand-read and result-write strobes go to the data path at fixed phases.

When execution leaves the straight-line path, the block replaces the wrong-path word it has already fetched with an all-zero no-operation word. Three cases do this: a relative branch, a conditional branch whose condition holds, and a test-and-skip whose condition holds. An absolute jump takes two words. The block latches the low target byte from the first word and assembles the full target when the second word executes.

The ALU and the data memory sit outside the block. They only see the strobes and the current instruction word. They return one condition bit, which is sampled at the end of Q4.

Top module: `qphase_sequencer`

## Requirements
- R1: The `phase` output steps 0,1,2,3 (Q1..Q4) on successive clocks and wraps from 3 back to 0.
- R2: A synchronous active-low reset sets `pm_addr` to 0, `phase` to 0 and `ir` to 0x0000, sets `bubble` high and holds both strobes low. The first cycle after reset only fetches (from address 0) and executes nothing.
- R3: `pm_addr` is the program counter. It changes only on the clock edge that leaves Q4, its bit 0 is always 0, and without a redirect it advances by 2.
- R4: The word at `pm_addr` at the end of Q4 becomes `ir` for the next instruction cycle, unless a NOP is inserted.
- R5: The opcode is `ir[15:12]`. Opcodes 0x1..0xA raise `rd_stb` in Q2 and `wr_stb` in Q4. Opcode 0xB raises only `rd_stb` in Q2. Opcodes 0x0, 0xC..0xF raise neither strobe.
- R6: Opcode 0xD is an unconditional relative branch. Its offset is the sign-extended word count `ir[10:0]`, and `ir[11]` is ignored. The new PC is the already-advanced PC plus twice the offset, and the next cycle executes an inserted NOP.
- R7: Opcode 0xE is a conditional branch with an 8-bit signed word offset in `ir[7:0]`. If `cond_in` is high at the end of Q4, it branches like R6. If not, execution continues with no inserted NOP.
- R8: Opcode 0xB is a test-and-skip. If `cond_in` is high at the end of Q4, the next fetched word is replaced by a NOP and the PC still advances by 2. If not, nothing changes.
- R9: Opcode 0xC starts an absolute jump and holds target bits 7:0 in `ir[7:0]`. The following word has top nibble 0xF and carries target bits 19:8 in its bits 11:0. The new PC is twice the 20-bit target. The jump takes three cycles, the last of which is an inserted NOP.
- R10: A word with top nibble 0xF that does not directly follow an executed 0xC word behaves as a NOP: no strobes and no redirect. This includes the second word of a skipped jump.
- R11: `bubble` is high during exactly those instruction cycles whose `ir` was forced to 0x0000 by an inserted NOP or by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock (one period per Q phase) |
| rst_n | input | 1 | Synchronous active-low reset |
| pm_addr | output | PC_W | Byte address of the word being fetched |
| pm_rdata | input | 16 | Program-memory word at `pm_addr`, valid by end of Q4 |
| cond_in | input | 1 | Condition result for skip and conditional branch, sampled at end of Q4 |
| phase | output | 2 | Current phase, 0..3 for Q1..Q4 |
| ir | output | 16 | Instruction word executing in this cycle |
| rd_stb | output | 1 | Operand-read strobe (Q2) |
| wr_stb | output | 1 | Result-write strobe (Q4) |
| bubble | output | 1 | The executing slot is an inserted NOP |

## Verification
Two functions can act in the same instruction cycle: a true skip inserts a NOP over the first word of an absolute jump, and the jump's second word then arrives orphaned. The bench sets this up by placing a test-and-skip, with the condition held high, directly in front of a two-word jump. It then expects one bubble cycle, followed by the orphaned second word executing with no strobes and no redirect, and fetching carrying on in sequence. A second overlap is a taken branch that lands on the address of a prior instruction. Here the bench compares the address trace with one computed from the offset arithmetic.

// File: rtl/seq_pkg.sv
// Shared constants, phase type and opcode class helpers for the sequencer.
// Assumes 16-bit instruction words with the opcode in the top nibble.
package seq_pkg;
    localparam int INSN_W      = 16;
    localparam int OPC_W       = 4;
    localparam int ABS_LO_W    = 8;
    localparam int ABS_HI_W    = 12;
    localparam int REL_LONG_W  = 11;
    localparam int REL_SHORT_W = 8;
    localparam int NUM_PHASES  = 4;
    localparam int PH_W        = $clog2(NUM_PHASES);

    typedef enum logic [PH_W-1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    localparam logic [OPC_W-1:0] OP_NOP       = 4'h0;
    localparam logic [OPC_W-1:0] OP_DATA_LAST = 4'hA;
    localparam logic [OPC_W-1:0] OP_TEST_SKIP = 4'hB;
    localparam logic [OPC_W-1:0] OP_JUMP_ABS  = 4'hC;
    localparam logic [OPC_W-1:0] OP_BR_REL    = 4'hD;
    localparam logic [OPC_W-1:0] OP_BR_COND   = 4'hE;
    localparam logic [OPC_W-1:0] OP_EXT_WORD  = 4'hF;

    localparam logic [INSN_W-1:0] NOP_WORD = '0;

    // Opcodes that read a data operand in Q2
    function automatic logic op_reads(input logic [OPC_W-1:0] op);
        return (op != OP_NOP) && (op <= OP_TEST_SKIP);
    endfunction

    // Opcodes that write a result in Q4
    function automatic logic op_writes(input logic [OPC_W-1:0] op);
        return (op != OP_NOP) && (op <= OP_DATA_LAST);
    endfunction
endpackage

// File: rtl/seq_phase_ctr.sv
// Phase counter: walks Q1..Q4 once per instruction cycle and flags Q4.
// Assumes one clock period per phase; reset parks the counter in Q1.
module seq_phase_ctr
    import seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_o,
    output logic   cyc_end_o
);
    phase_e ph_q;

    // Advance one phase per clock, wrapping Q4 -> Q1
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_Q1;
        else        ph_q <= phase_e'(ph_q + PH_W'(1));
    end

    assign phase_o   = ph_q;
    assign cyc_end_o = (ph_q == PH_Q4);

    p_wrap_to_q1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_Q4) |=> (phase_o == PH_Q1));

    p_q1_to_q2_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_Q1) |=> (phase_o == PH_Q2));
endmodule

// File: rtl/seq_decode.sv
// Instruction classifier: turns the executing word, the pending-jump flag
// and the condition bit into strobe enables and flow-change requests.
// Assumes opcode in the top nibble; offsets are signed word counts.
module seq_decode
    import seq_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic [INSN_W-1:0] ir_i,
    input  logic              abs_pend_i,
    input  logic              cond_i,
    output logic              rd_en_o,
    output logic              wr_en_o,
    output logic              skip_o,
    output logic              rel_take_o,
    output logic              abs_start_o,
    output logic              abs_take_o,
    output logic [PC_W-1:0]   rel_ofs_o
);
    localparam int LONG_PAD  = PC_W - REL_LONG_W - 1;
    localparam int SHORT_PAD = PC_W - REL_SHORT_W - 1;

    logic [OPC_W-1:0] op;
    logic [PC_W-1:0]  ofs_long;
    logic [PC_W-1:0]  ofs_short;

    assign op = ir_i[INSN_W-1 -: OPC_W];

    // Byte offsets: sign-extended word counts times two
    assign ofs_long  = {{LONG_PAD{ir_i[REL_LONG_W-1]}},  ir_i[REL_LONG_W-1:0],  1'b0};
    assign ofs_short = {{SHORT_PAD{ir_i[REL_SHORT_W-1]}}, ir_i[REL_SHORT_W-1:0], 1'b0};

    // Classify the executing word into flow-change requests
    always_comb begin
        skip_o      = 1'b0;
        rel_take_o  = 1'b0;
        abs_start_o = 1'b0;
        abs_take_o  = 1'b0;
        rel_ofs_o   = ofs_long;
        case (op)
            OP_TEST_SKIP: skip_o      = cond_i;
            OP_JUMP_ABS:  abs_start_o = 1'b1;
            OP_BR_REL:    rel_take_o  = 1'b1;
            OP_BR_COND: begin
                rel_take_o = cond_i;
                rel_ofs_o  = ofs_short;
            end
            OP_EXT_WORD:  abs_take_o  = abs_pend_i;
            default: ;
        endcase
    end

    assign rd_en_o = op_reads(op);
    assign wr_en_o = op_writes(op);
endmodule

// File: rtl/seq_pc_unit.sv
// Program counter: advances by 2 at each cycle end, or loads a relative
// or absolute target. Assumes PC_W > 20 so the absolute target fits.
module seq_pc_unit
    import seq_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_end_i,
    input  logic                rel_take_i,
    input  logic [PC_W-1:0]     rel_ofs_i,
    input  logic                abs_take_i,
    input  logic [ABS_HI_W-1:0] abs_hi_i,
    input  logic [ABS_LO_W-1:0] abs_lo_i,
    output logic [PC_W-1:0]     pc_o,
    output logic                redirect_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(2);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_nxt;
    logic [PC_W-1:0] abs_tgt;
    logic [PC_W-1:0] rel_tgt;

    assign abs_tgt    = PC_W'({abs_hi_i, abs_lo_i, 1'b0});
    assign rel_tgt    = pc_q + rel_ofs_i;
    assign redirect_o = rel_take_i | abs_take_i;

    // Select the next fetch address
    always_comb begin
        if (abs_take_i)      pc_nxt = abs_tgt;
        else if (rel_take_i) pc_nxt = rel_tgt;
        else                 pc_nxt = pc_q + STEP;
    end

    // Update the program counter on the edge that leaves Q4
    always_ff @(posedge clk) begin
        if (!rst_n)         pc_q <= '0;
        else if (cyc_end_i) pc_q <= pc_nxt;
    end

    assign pc_o = pc_q;

    p_pc_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[0] == 1'b0);

    p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end_i |=> $stable(pc_q));

    p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end_i && !redirect_o) |=> (pc_q == $past(pc_q) + STEP));
endmodule

// File: rtl/qphase_sequencer.sv
// Four-phase fetch/execute sequencer: holds the instruction register,
// inserts NOP slots on flow changes and true skips, and assembles the
// two-word absolute jump. Assumes program memory answers within a cycle.
module qphase_sequencer
    import seq_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   pm_addr,
    input  logic [INSN_W-1:0] pm_rdata,
    input  logic              cond_in,
    output logic [PH_W-1:0]   phase,
    output logic [INSN_W-1:0] ir,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              bubble
);
    phase_e              ph;
    logic                cyc_end;
    logic [INSN_W-1:0]   ir_q;
    logic                bub_q;
    logic                abs_pend_q;
    logic [ABS_LO_W-1:0] abs_lo_q;
    logic                rd_en, wr_en, skip, rel_take, abs_start, abs_take;
    logic [PC_W-1:0]     rel_ofs;
    logic                redirect;
    logic                flush;

    seq_phase_ctr u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_o   (ph),
        .cyc_end_o (cyc_end)
    );

    seq_decode #(.PC_W(PC_W)) u_decode (
        .ir_i        (ir_q),
        .abs_pend_i  (abs_pend_q),
        .cond_i      (cond_in),
        .rd_en_o     (rd_en),
        .wr_en_o     (wr_en),
        .skip_o      (skip),
        .rel_take_o  (rel_take),
        .abs_start_o (abs_start),
        .abs_take_o  (abs_take),
        .rel_ofs_o   (rel_ofs)
    );

    seq_pc_unit #(.PC_W(PC_W)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_end_i  (cyc_end),
        .rel_take_i (rel_take),
        .rel_ofs_i  (rel_ofs),
        .abs_take_i (abs_take),
        .abs_hi_i   (ir_q[ABS_HI_W-1:0]),
        .abs_lo_i   (abs_lo_q),
        .pc_o       (pm_addr),
        .redirect_o (redirect)
    );

    assign flush = skip | redirect;

    // Load the fetched word, or a NOP on flush, at the Q4 -> Q1 edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q       <= NOP_WORD;
            bub_q      <= 1'b1;
            abs_pend_q <= 1'b0;
            abs_lo_q   <= '0;
        end else if (cyc_end) begin
            ir_q       <= flush ? NOP_WORD : pm_rdata;
            bub_q      <= flush;
            abs_pend_q <= abs_start;
            if (abs_start) abs_lo_q <= ir_q[ABS_LO_W-1:0];
        end
    end

    assign phase  = ph;
    assign ir     = ir_q;
    assign bubble = bub_q;
    assign rd_stb = (ph == PH_Q2) && rd_en;
    assign wr_stb = (ph == PH_Q4) && wr_en;

    p_ir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> $stable(ir_q));

    p_flush_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && flush) |=> (bubble && ir == NOP_WORD));

    p_bubble_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> (!rd_stb && !wr_stb && !redirect));

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    p_orphan_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ir[INSN_W-1 -: OPC_W] == OP_EXT_WORD && !abs_pend_q)
            |-> (!redirect && !rd_stb && !wr_stb));

    p_jump_arms_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && abs_start) |=> abs_pend_q);
endmodule

// File: tb/qphase_sequencer_bench.sv
module qphase_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 21;
    localparam int ROWS       = 21;

    typedef struct packed {
        logic [7:0]  addr;
        logic [15:0] word;
        logic        bub;
        logic        cond;
    } row_t;

    // Expected trace per instruction cycle: fetch address, executing word,
    // bubble flag, and the condition bit driven during that cycle.
    localparam row_t TRACE [0:ROWS-1] = '{
        '{8'h00, 16'h0000, 1'b1, 1'b0},
        '{8'h02, 16'h1234, 1'b0, 1'b1},
        '{8'h04, 16'hB000, 1'b0, 1'b1},
        '{8'h06, 16'h0000, 1'b1, 1'b0},
        '{8'h08, 16'hB000, 1'b0, 1'b0},
        '{8'h0A, 16'h2222, 1'b0, 1'b1},
        '{8'h0C, 16'hE003, 1'b0, 1'b0},
        '{8'h0E, 16'hE002, 1'b0, 1'b1},
        '{8'h12, 16'h0000, 1'b1, 1'b0},
        '{8'h14, 16'hD002, 1'b0, 1'b0},
        '{8'h18, 16'h0000, 1'b1, 1'b0},
        '{8'h1A, 16'hC020, 1'b0, 1'b0},
        '{8'h1C, 16'hF000, 1'b0, 1'b0},
        '{8'h40, 16'h0000, 1'b1, 1'b0},
        '{8'h42, 16'hB000, 1'b0, 1'b1},
        '{8'h44, 16'h0000, 1'b1, 1'b0},
        '{8'h46, 16'hF000, 1'b0, 1'b1},
        '{8'h48, 16'h9999, 1'b0, 1'b0},
        '{8'h4A, 16'hDFFA, 1'b0, 1'b0},
        '{8'h3E, 16'h0000, 1'b1, 1'b0},
        '{8'h40, 16'h6666, 1'b0, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [PC_W-1:0] pm_addr;
    logic [15:0]     pm_rdata;
    logic            cond_in;
    logic [1:0]      phase;
    logic [15:0]     ir;
    logic            rd_stb, wr_stb, bubble;
    logic [15:0]     mem [0:63];
    int              n_chk  = 0;
    int              n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pm_rdata = mem[pm_addr[6:1]];

    qphase_sequencer #(.PC_W(PC_W)) u_qphase_sequencer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pm_addr  (pm_addr),
        .pm_rdata (pm_rdata),
        .cond_in  (cond_in),
        .phase    (phase),
        .ir       (ir),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .bubble   (bubble)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Opcode classes from R5
    function automatic logic exp_rd(input logic [15:0] w);
        return (w[15:12] >= 4'h1) && (w[15:12] <= 4'hB);
    endfunction
    function automatic logic exp_wr(input logic [15:0] w);
        return (w[15:12] >= 4'h1) && (w[15:12] <= 4'hA);
    endfunction

    // Requirement that each trace row chiefly exercises
    function automatic string row_tag(input int i);
        case (i)
            2, 3, 4:        return "R8";
            6, 7, 8:        return "R7";
            9, 10, 18, 19:  return "R6";
            11, 12, 13:     return "R9";
            14, 15, 16:     return "R10";
            default:        return "R4";
        endcase
    endfunction

    task automatic chk_reset_state();
        chk("R2", "pm_addr", 32'(pm_addr), 32'h0);
        chk("R2", "phase",   32'(phase),   32'h0);
        chk("R2", "ir",      32'(ir),      32'h0);
        chk("R2", "bubble",  32'(bubble),  32'h1);
        chk("R2", "strobes", {30'h0, rd_stb, wr_stb}, 32'h0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        mem[0]  = 16'h1234; mem[1]  = 16'hB000; mem[2]  = 16'h5111;
        mem[3]  = 16'hB000; mem[4]  = 16'h2222; mem[5]  = 16'hE003;
        mem[6]  = 16'hE002; mem[7]  = 16'h7777; mem[8]  = 16'h8888;
        mem[9]  = 16'hD002; mem[10] = 16'h3333; mem[12] = 16'hC020;
        mem[13] = 16'hF000; mem[14] = 16'h4444; mem[31] = 16'h6666;
        mem[32] = 16'hB000; mem[33] = 16'hC010; mem[34] = 16'hF000;
        mem[35] = 16'h9999; mem[36] = 16'hDFFA;

        rst_n   = 1'b0;
        cond_in = 1'b0;
        repeat (3) @(negedge clk);
        chk_reset_state();
        rst_n = 1'b1;

        // Table walk: one iteration per instruction cycle, starting in Q1
        for (int i = 0; i < ROWS; i++) begin
            cond_in = TRACE[i].cond;
            chk("R1", "phase Q1", 32'(phase), 32'h0);
            chk("R3", "pm_addr", 32'(pm_addr), {24'h0, TRACE[i].addr});
            chk(row_tag(i), "ir", 32'(ir), {16'h0, TRACE[i].word});
            chk("R11", "bubble", 32'(bubble), 32'(TRACE[i].bub));
            @(negedge clk);
            chk("R1", "phase Q2", 32'(phase), 32'h1);
            chk("R5", "rd_stb Q2", 32'(rd_stb), 32'(exp_rd(TRACE[i].word)));
            chk("R5", "wr_stb Q2", 32'(wr_stb), 32'h0);
            @(negedge clk);
            chk("R1", "phase Q3", 32'(phase), 32'h2);
            @(negedge clk);
            chk("R1", "phase Q4", 32'(phase), 32'h3);
            chk("R5", "wr_stb Q4", 32'(wr_stb), 32'(exp_wr(TRACE[i].word)));
            chk("R5", "rd_stb Q4", 32'(rd_stb), 32'h0);
            @(negedge clk);
        end

        // Directed: reset asserted in the middle of an instruction cycle
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_reset_state();
        rst_n = 1'b1;
        // First cycle after reset fetches only: no read strobe in Q2
        @(negedge clk);
        chk("R2", "fetch-only rd_stb", 32'(rd_stb), 32'h0);
        @(negedge clk);
        @(negedge clk);
        chk("R2", "fetch-only wr_stb", 32'(wr_stb), 32'h0);
        @(negedge clk);
        // Next cycle executes the word at address 0, fetching address 2
        chk("R4", "ir after reset", 32'(ir), 32'h1234);
        chk("R3", "pm_addr after reset", 32'(pm_addr), 32'h2);
        chk("R11", "bubble after reset", 32'(bubble), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule